// File: doc/BRIEF.md
# Reset and Exception Entry Sequencer

This block is the control sequencer that a 32-bit processor core runs when a reset or an exception begins. For a reset it reads the starting program counter and stack pointer from two fixed vector words and loads default values into the control registers. Power-on reset and manual reset use different vector words. For any other exception it pushes the return PC and then the status register onto the stack through the stack-pointer register (R15). For interrupts it then raises the SR mask to the accepted level. It reads the handler address from the vector table and pulses `done` with the new PC. All memory traffic goes through one 32-bit request/acknowledge port. An interrupt taken with register banking enabled first requests a bank save from the bank storage through a request/acknowledge handshake.

The state machine has seven named states. `ST_IDLE` waits. `ST_RST_PC` and `ST_RST_SP` fetch the reset vector pair. `ST_BANK` waits for the bank-save acknowledge. `ST_PUSH_PC` and `ST_PUSH_SR` write the stack. `ST_VEC` reads the handler vector.

Transitions:
- IDLE→RST_PC on `reset_req`. This transition is also taken from every other state, and it wins over everything else.
- IDLE→BANK on an accepted interrupt with `bank_en`.
- IDLE→PUSH_PC on any other accepted exception.
- RST_PC→RST_SP, PUSH_PC→PUSH_SR, PUSH_SR→VEC, RST_SP→IDLE and VEC→IDLE, each on `mem_ack`.
- BANK→PUSH_PC on `bank_ack`.

Top module: `exc_entry_seq`

## Requirements
- R1: After a power-on reset request (`reset_manual`=0), the block reads the PC from address 0x00000000 and then the SP from 0x00000004. The PC value appears on `pc_out` and the SP value on `sp_out`.
- R2: After a manual reset request (`reset_manual`=1), the PC is read from 0x00000008 and then the SP from 0x0000000C.
- R3: In the cycle after any reset request, VBR reads 0, the SR mask field SR[7:4] reads 0xF and the bank number reads 0.
- R4: FPSCR becomes 0x00040001 after a power-on reset request and keeps its value across a manual reset request.
- R5: An accepted exception makes two writes in this order: the return PC (`exc_pc`) to SP−4, then the SR value held before the exception to SP−8. SP ends 8 lower, and both writes complete before the vector read.
- R6: The handler address is read from VBR + 4×vector number. The word read becomes `pc_out`, and `done` is high for exactly one cycle, in the cycle that `pc_out` first shows it.
- R7: Exception class is encoded on `exc_class` as 0 = interrupt, 1 = address error, 2 = instruction, 3 = other. For class 0, SR[7:4] takes `exc_level` after the SR push. For classes 1 to 3 the mask is left unchanged.
- R8: A class 0 exception with `bank_en`=1 raises `bank_req`, with no memory request, until `bank_ack`. Each acknowledge adds 1 to `bank_num`. Other classes never raise `bank_req`.
- R9: A memory request holds its address, direction and write data until acknowledged, and the sequence does not advance without `mem_ack`.
- R10: `reset_req` aborts any sequence in progress, and the next cycle fetches the reset PC vector. `exc_req` while `busy` is ignored.
- R11: While `rst_n` is low at a clock edge, the block goes idle with PC, SP, VBR, FPSCR and bank number at 0 and SR at 0x000000F0.
- R12: `vbr_wr` loads `vbr_wdata` into VBR when no reset request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reset_req | input | 1 | Start a reset sequence (synchronous, highest priority) |
| reset_manual | input | 1 | 1 = manual reset vectors, 0 = power-on vectors |
| exc_req | input | 1 | Start an exception sequence (taken only when idle) |
| exc_class | input | 2 | Exception class: 0 interrupt, 1 address error, 2 instruction, 3 other |
| exc_vec | input | 8 | Vector number |
| exc_level | input | 4 | Accepted interrupt level |
| exc_pc | input | 32 | Return PC to push |
| bank_en | input | 1 | Register banking enabled for interrupts |
| bank_req | output | 1 | Bank save request |
| bank_ack | input | 1 | Bank save done |
| vbr_wr | input | 1 | VBR write strobe |
| vbr_wdata | input | 32 | VBR write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| pc_out | output | 32 | Program counter |
| sp_out | output | 32 | Stack pointer (R15) |
| vbr_out | output | 32 | Vector base |
| sr_out | output | 32 | Status register, mask in bits 7:4 |
| fpscr_out | output | 32 | Floating-point status/control |
| bank_num | output | 4 | Bank number field |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when the new PC is loaded |

## Verification
The hardest case to reach is a reset request that lands in the middle of an exception, while a stack write is still waiting for its acknowledge. The bench makes the memory model stretch every acknowledge by three cycles. It starts an interrupt and raises a manual reset two cycles later, before any push has completed. It then checks that no stack write ever completes, that FPSCR is untouched, and that the next accesses are the manual vector pair. A second exception request injected in the middle of a sequence shows that a busy block ignores it.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN       = 32;
    localparam int MASK_W     = 4;
    localparam int MASK_LSB   = 4;
    localparam int WORD_BYTES = XLEN / 8;

    localparam logic [XLEN-1:0] POR_PC_VEC  = 32'h0000_0000;
    localparam logic [XLEN-1:0] POR_SP_VEC  = 32'h0000_0004;
    localparam logic [XLEN-1:0] MRST_PC_VEC = 32'h0000_0008;
    localparam logic [XLEN-1:0] MRST_SP_VEC = 32'h0000_000C;
    localparam logic [XLEN-1:0] FPSCR_POR   = 32'h0004_0001;
    localparam logic [XLEN-1:0] SR_RST      = 32'h0000_00F0;
    localparam logic [MASK_W-1:0] MASK_ALL  = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_PC,
        ST_RST_SP,
        ST_BANK,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_VEC
    } seq_state_t;

    localparam logic [1:0] EC_INTR = 2'd0;
endpackage

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_req,
    input  logic       exc_req,
    input  logic       intr_bank,
    input  logic       bank_ack,
    input  logic       mem_ack,
    output seq_state_t state
);
    seq_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (exc_req) nxt = intr_bank ? ST_BANK : ST_PUSH_PC;
            ST_RST_PC:  if (mem_ack) nxt = ST_RST_SP;
            ST_RST_SP:  if (mem_ack) nxt = ST_IDLE;
            ST_BANK:    if (bank_ack) nxt = ST_PUSH_PC;
            ST_PUSH_PC: if (mem_ack) nxt = ST_PUSH_SR;
            ST_PUSH_SR: if (mem_ack) nxt = ST_VEC;
            ST_VEC:     if (mem_ack) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        if (reset_req) nxt = ST_RST_PC;
    end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              reset_req,
    input  logic              reset_manual,
    input  logic              exc_accept,
    input  logic [1:0]        exc_class,
    input  logic [VEC_W-1:0]  exc_vec,
    input  logic [MASK_W-1:0] exc_level,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              bank_ack,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              vbr_wr,
    input  logic [XLEN-1:0]   vbr_wdata,
    output logic [XLEN-1:0]   pc_q,
    output logic [XLEN-1:0]   sp_q,
    output logic [XLEN-1:0]   vbr_q,
    output logic [XLEN-1:0]   sr_q,
    output logic [XLEN-1:0]   fpscr_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              manual_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic [XLEN-1:0]   ret_pc_q,
    output logic              done_q
);
    logic [1:0]        cls_q;
    logic [MASK_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            sp_q     <= '0;
            vbr_q    <= '0;
            sr_q     <= SR_RST;
            fpscr_q  <= '0;
            bank_q   <= '0;
            manual_q <= 1'b0;
            vec_q    <= '0;
            ret_pc_q <= '0;
            cls_q    <= '0;
            lvl_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (reset_req) begin
                vbr_q                      <= '0;
                sr_q[MASK_LSB +: MASK_W]   <= MASK_ALL;
                bank_q                     <= '0;
                manual_q                   <= reset_manual;
                if (!reset_manual) fpscr_q <= FPSCR_POR;
            end else begin
                if (vbr_wr) vbr_q <= vbr_wdata;
                if (exc_accept) begin
                    cls_q    <= exc_class;
                    vec_q    <= exc_vec;
                    lvl_q    <= exc_level;
                    ret_pc_q <= exc_pc;
                end
                unique case (state)
                    ST_RST_PC: if (mem_ack) pc_q <= mem_rdata;
                    ST_RST_SP: if (mem_ack) begin
                        sp_q   <= mem_rdata;
                        done_q <= 1'b1;
                    end
                    ST_BANK: if (bank_ack) bank_q <= bank_q + 1'b1;
                    ST_PUSH_PC: if (mem_ack) sp_q <= sp_q - XLEN'(WORD_BYTES);
                    ST_PUSH_SR: if (mem_ack) begin
                        sp_q <= sp_q - XLEN'(WORD_BYTES);
                        if (cls_q == EC_INTR) sr_q[MASK_LSB +: MASK_W] <= lvl_q;
                    end
                    ST_VEC: if (mem_ack) begin
                        pc_q   <= mem_rdata;
                        done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/exc_mem.sv
module exc_mem
    import exc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  seq_state_t       state,
    input  logic             manual_q,
    input  logic [XLEN-1:0]  sp_q,
    input  logic [XLEN-1:0]  vbr_q,
    input  logic [XLEN-1:0]  sr_q,
    input  logic [VEC_W-1:0] vec_q,
    input  logic [XLEN-1:0]  ret_pc_q,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             bank_req,
    output logic             busy
);
    localparam int PAD_W = XLEN - VEC_W - 2;

    logic [XLEN-1:0] vec_off;
    logic [XLEN-1:0] push_addr;

    assign vec_off   = {{PAD_W{1'b0}}, vec_q, 2'b00};
    assign push_addr = sp_q - XLEN'(WORD_BYTES);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        bank_req  = 1'b0;
        busy      = (state != ST_IDLE);
        unique case (state)
            ST_RST_PC: begin
                mem_req  = 1'b1;
                mem_addr = manual_q ? MRST_PC_VEC : POR_PC_VEC;
            end
            ST_RST_SP: begin
                mem_req  = 1'b1;
                mem_addr = manual_q ? MRST_SP_VEC : POR_SP_VEC;
            end
            ST_BANK: bank_req = 1'b1;
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = ret_pc_q;
            end
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = sr_q;
            end
            ST_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vbr_q + vec_off;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              reset_manual,
    input  logic              exc_req,
    input  logic [1:0]        exc_class,
    input  logic [VEC_W-1:0]  exc_vec,
    input  logic [MASK_W-1:0] exc_level,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              bank_en,
    output logic              bank_req,
    input  logic              bank_ack,
    input  logic              vbr_wr,
    input  logic [XLEN-1:0]   vbr_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ack,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   sp_out,
    output logic [XLEN-1:0]   vbr_out,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   fpscr_out,
    output logic [BANK_W-1:0] bank_num,
    output logic              busy,
    output logic              done
);
    seq_state_t       state;
    logic             exc_accept;
    logic             intr_bank;
    logic             manual_q;
    logic [VEC_W-1:0] vec_q;
    logic [XLEN-1:0]  ret_pc_q;

    assign exc_accept = (state == ST_IDLE) && exc_req && !reset_req;
    assign intr_bank  = (exc_class == EC_INTR) && bank_en;

    exc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .exc_req   (exc_req),
        .intr_bank (intr_bank),
        .bank_ack  (bank_ack),
        .mem_ack   (mem_ack),
        .state     (state)
    );

    exc_regs #(.VEC_W(VEC_W), .BANK_W(BANK_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .reset_req    (reset_req),
        .reset_manual (reset_manual),
        .exc_accept   (exc_accept),
        .exc_class    (exc_class),
        .exc_vec      (exc_vec),
        .exc_level    (exc_level),
        .exc_pc       (exc_pc),
        .bank_ack     (bank_ack),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .vbr_wr       (vbr_wr),
        .vbr_wdata    (vbr_wdata),
        .pc_q         (pc_out),
        .sp_q         (sp_out),
        .vbr_q        (vbr_out),
        .sr_q         (sr_out),
        .fpscr_q      (fpscr_out),
        .bank_q       (bank_num),
        .manual_q     (manual_q),
        .vec_q        (vec_q),
        .ret_pc_q     (ret_pc_q),
        .done_q       (done)
    );

    exc_mem #(.VEC_W(VEC_W)) u_mem (
        .state     (state),
        .manual_q  (manual_q),
        .sp_q      (sp_out),
        .vbr_q     (vbr_out),
        .sr_q      (sr_out),
        .vec_q     (vec_q),
        .ret_pc_q  (ret_pc_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .bank_req  (bank_req),
        .busy      (busy)
    );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reset_req,
    input logic              reset_manual,
    input logic              bank_req,
    input logic              bank_ack,
    input logic              vbr_wr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [XLEN-1:0]   mem_addr,
    input logic              mem_ack,
    input logic [XLEN-1:0]   pc_out,
    input logic [XLEN-1:0]   sp_out,
    input logic [XLEN-1:0]   vbr_out,
    input logic [XLEN-1:0]   sr_out,
    input logic [XLEN-1:0]   fpscr_out,
    input logic [BANK_W-1:0] bank_num,
    input logic              busy,
    input logic              done
);
    a_r3_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (vbr_out == '0) && (sr_out[MASK_LSB +: MASK_W] == MASK_ALL)
                      && (bank_num == '0) && busy);

    a_r4_fpscr_por: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !reset_manual) |=> (fpscr_out == FPSCR_POR));

    a_r4_fpscr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && reset_manual) |=> $stable(fpscr_out));

    a_r5_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == sp_out - XLEN'(WORD_BYTES)));

    a_r5_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && !reset_req)
            |=> (sp_out == $past(sp_out) - XLEN'(WORD_BYTES)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_bank_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req && bank_ack && !reset_req) |=> (bank_num == $past(bank_num) + 1'b1));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reset_req && !vbr_wr)
            |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r10_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (mem_req && !mem_we
                       && mem_addr == ($past(reset_manual) ? MRST_PC_VEC : POR_PC_VEC)));

    a_r11_block_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy && pc_out == '0 && sr_out == SR_RST));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.BANK_W(BANK_W)) u_chk (.*);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 1'b0, reset_manual = 1'b0;
    logic        exc_req = 1'b0;
    logic [1:0]  exc_class = '0;
    logic [7:0]  exc_vec = '0;
    logic [3:0]  exc_level = '0;
    logic [31:0] exc_pc = '0;
    logic        bank_en = 1'b0, bank_ack = 1'b0, bank_req;
    logic        vbr_wr = 1'b0;
    logic [31:0] vbr_wdata = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [31:0] pc_out, sp_out, vbr_out, sr_out, fpscr_out;
    logic [3:0]  bank_num;
    logic        busy, done;

    always #2 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (.*);

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] data;
        string       tag;
    } tx_t;
    tx_t exp_q[$];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int mem_wait = 0, cnt = 0, bcnt = 0;
    logic prev_req = 1'b0, rst_seen = 1'b0, bank_seen = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [31:0] m_sp = '0, m_sr = 32'hF0, m_vbr = '0, m_fpscr = '0;
    logic [3:0]  m_bank = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return 32'h1000_0000 + (a << 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic score();
        tx_t e;
        if (exp_q.size() == 0) begin
            check("R9", mem_addr, 32'hDEAD_DEAD, "unexpected access");
        end else begin
            e = exp_q.pop_front();
            check(e.tag, mem_addr, e.addr, "access address");
            check(e.tag, {31'b0, mem_we}, {31'b0, e.we}, "access direction");
            if (e.we) check(e.tag, mem_wdata, e.data, "write data");
        end
    endtask

    always @(posedge clk) rst_seen <= reset_req;

    // monitor and memory/bank responder
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            bank_ack <= 1'b0;
            cnt = 0;
            bcnt = 0;
        end else begin
            if (mem_req && prev_req && !mem_ack && !rst_seen)
                check("R9", mem_addr, prev_addr, "address held while waiting");
            if (rst_seen) cnt = 0;
            if (mem_req) begin
                if (cnt >= mem_wait) begin
                    mem_ack   <= 1'b1;
                    mem_rdata <= rd(mem_addr);
                    cnt = 0;
                    score();
                end else begin
                    mem_ack <= 1'b0;
                    cnt++;
                end
            end else begin
                mem_ack <= 1'b0;
                cnt = 0;
            end
            prev_req  = mem_req;
            prev_addr = mem_addr;
            if (bank_req && mem_req) check("R8", 32'd1, 32'd0, "memory request during bank save");
            if (bank_req) begin
                bank_seen = 1'b1;
                if (bcnt >= 2) begin bank_ack <= 1'b1; bcnt = 0; end
                else begin bank_ack <= 1'b0; bcnt++; end
            end else begin
                bank_ack <= 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_done(input string req);
        logic seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
        check(req, {31'b0, seen}, 32'd1, "done pulse seen");
    endtask

    task automatic do_reset(input logic manual, input int wt);
        logic [31:0] pa, sa;
        string tg;
        pa = manual ? 32'h8 : 32'h0;
        sa = manual ? 32'hC : 32'h4;
        tg = manual ? "R2" : "R1";
        exp_q.delete();
        exp_q.push_back('{pa, 1'b0, 32'h0, tg});
        exp_q.push_back('{sa, 1'b0, 32'h0, tg});
        mem_wait = wt;
        @(negedge clk);
        reset_req = 1'b1;
        reset_manual = manual;
        @(negedge clk);
        reset_req = 1'b0;
        if (!manual) m_fpscr = 32'h0004_0001;
        m_sr[7:4] = 4'hF;
        m_vbr = '0;
        m_bank = '0;
        check("R3", vbr_out, 32'h0, "VBR after reset");
        check("R3", {28'b0, sr_out[7:4]}, 32'hF, "SR mask after reset");
        check("R3", {28'b0, bank_num}, 32'h0, "bank number after reset");
        check("R4", fpscr_out, m_fpscr, "FPSCR after reset");
        check("R10", mem_addr, pa, "first access after reset");
        wait_done(tg);
        check(tg, pc_out, rd(pa), "reset PC");
        check(tg, sp_out, rd(sa), "reset SP");
        m_sp = rd(sa);
    endtask

    task automatic do_exc(input logic [1:0] cls, input logic [7:0] vec, input logic [3:0] lvl,
                          input logic [31:0] rpc, input logic ben, input int wt, input logic inject);
        logic [31:0] va;
        va = m_vbr + {22'd0, vec, 2'b00};
        exp_q.push_back('{m_sp - 32'd4, 1'b1, rpc, "R5"});
        exp_q.push_back('{m_sp - 32'd8, 1'b1, m_sr, "R5"});
        exp_q.push_back('{va, 1'b0, 32'h0, "R6"});
        mem_wait = wt;
        bank_seen = 1'b0;
        @(negedge clk);
        exc_req = 1'b1; exc_class = cls; exc_vec = vec; exc_level = lvl;
        exc_pc = rpc; bank_en = ben;
        @(negedge clk);
        exc_req = 1'b0;
        if (inject) begin
            @(negedge clk);
            exc_req = 1'b1; exc_class = 2'd0; exc_vec = 8'h33; exc_level = 4'h1;
            @(negedge clk);
            exc_req = 1'b0;
        end
        wait_done("R6");
        check("R6", pc_out, rd(va), "handler PC");
        check("R5", sp_out, m_sp - 32'd8, "SP after pushes");
        m_sp = m_sp - 32'd8;
        if (cls == 2'd0) m_sr[7:4] = lvl;
        check("R7", sr_out, m_sr, "SR after entry");
        check("R5", exp_q.size(), 32'd0, "all accesses done");
        if (cls == 2'd0 && ben) begin
            m_bank = m_bank + 4'd1;
            check("R8", {31'b0, bank_seen}, 32'd1, "bank save requested");
        end else begin
            check("R8", {31'b0, bank_seen}, 32'd0, "no bank save");
        end
        check("R8", {28'b0, bank_num}, {28'b0, m_bank}, "bank number");
        @(negedge clk);
        check("R6", {31'b0, done}, 32'd0, "done one cycle");
        if (inject) begin
            repeat (3) @(negedge clk);
            check("R10", {31'b0, busy}, 32'd0, "request while busy ignored");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", pc_out, 32'h0, "PC in block reset");
        check("R11", sr_out, 32'hF0, "SR in block reset");
        check("R11", fpscr_out, 32'h0, "FPSCR in block reset");
        check("R11", {31'b0, busy}, 32'd0, "idle in block reset");
        rst_n = 1'b1;

        do_reset(1'b0, 0);

        @(negedge clk);
        vbr_wr = 1'b1; vbr_wdata = 32'h0000_2000;
        @(negedge clk);
        vbr_wr = 1'b0;
        m_vbr = 32'h0000_2000;
        check("R12", vbr_out, 32'h0000_2000, "VBR write");

        do_exc(2'd2, 8'd9,  4'h7, 32'h0000_4444, 1'b0, 1, 1'b0);
        do_exc(2'd0, 8'd64, 4'h5, 32'h0000_5550, 1'b0, 2, 1'b1);
        do_exc(2'd0, 8'd70, 4'h3, 32'h0000_6660, 1'b1, 0, 1'b0);
        do_exc(2'd1, 8'd9,  4'hC, 32'h0000_7770, 1'b1, 0, 1'b0);

        // manual reset arriving while a stack write waits for its acknowledge
        mem_wait = 3;
        @(negedge clk);
        exc_req = 1'b1; exc_class = 2'd0; exc_vec = 8'd80; exc_level = 4'h2; bank_en = 1'b0;
        @(negedge clk);
        exc_req = 1'b0;
        do_reset(1'b1, 3);

        do_exc(2'd3, 8'd2, 4'h9, 32'h0000_8880, 1'b0, 0, 1'b0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule